// File: doc/BRIEF.md
# Error-Feedback Fractional Toggle Generator

This block turns a fixed-point period word into a square wave. The word is unsigned 8.24: bits [31:24] hold whole clock cycles and bits [23:0] hold a binary fraction. It gives the target length of one half-period. Each half-period has to last a whole number of clock cycles. The block therefore rounds the target to the nearest integer and keeps the rounding error in a signed accumulator. That error is fed into the next rounding, so the average half-period matches the word over time, even when the word has a fraction.

Every half-period is made of two parts: a fixed overhead of `OVERHEAD` cycles spent by the output engine, and a variable countdown. The countdown length is stored as an 8-bit count. The word is not followed continuously. It is sampled at the first half-period of each batch of `BATCH` (32) half-periods and held for the rest of that batch. While the enable is low the block rests: the output is low and all of its loop state is cleared. A debug port shows the 8-bit count of the half-period in progress. A sticky flag records any count that had to be clamped.

Top module: `frac_toggle_gen`

## Requirements
- R1: While `en` is low the output `wave` is 0 from the next clock edge on. On the first clock edge with `en` high, the first half-period starts and `wave` goes to 1.
- R2: Each half-period lasts exactly `net + OVERHEAD` clock cycles, with `net = raw - OVERHEAD` whenever that value lies in 1..255. `wave` toggles at the end of each half-period.
- R3: `raw` is the word in use minus the accumulator, plus 2^23, shifted arithmetically right by 24. This is round-to-nearest, and a fraction of exactly one half rounds up: word 0x0480_0000 gives a first half-period of 5 cycles.
- R4: After each half-period is scheduled, the 32-bit signed accumulator becomes `acc + raw*2^24 - word`. It is kept across batch boundaries.
- R5: The word input is sampled only at half-periods with index 0, 32, 64, … counted from enable. A change to the word in the middle of a batch has no effect until the next batch starts.
- R6: If `net` would fall below 1, 1 is used instead. If it would rise above 255, 255 is used instead. Either case sets `clamp_flag`, which stays 1 until `rst_n` is asserted and is not cleared by `en`.
- R7: `half_cnt` shows the `net` value of the half-period in progress. It changes on the same edge as `wave`, and it is 0 after reset.
- R8: Over N consecutive half-periods at a constant word W, the elapsed cycle count differs from N·W/2^24 by less than one cycle.
- R9: There are no gap cycles: the next count loads on the same edge as the toggle. A half-period is never shorter than 2 cycles.
- R10: Dropping `en` clears the accumulator and the batch position, so a restart with the same word gives the same sequence of half-periods as the first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low clears the loop state |
| word | input | INT_W+FRAC_W (32) | Half-period in clock cycles, unsigned 8.24 |
| wave | output | 1 | Square-wave output |
| half_cnt | output | CNT_W (8) | Count of the current half-period (debug) |
| clamp_flag | output | 1 | Sticky: a count was clamped |

## Verification
The assertions on half-period shape take for granted that `OVERHEAD` is at least 1. They count a change of `wave` as a toggle only when `en` was high on the edge that made it, so that a forced low on disable is not mistaken for a half-period. The stimulus holds `word` steady except for one deliberate change at a known half-period, made on a falling edge. It leaves `en` high long enough for every expected half-period to complete before dropping it. The words are chosen to keep `net` inside its range, except in the one phase that exercises the low clamp.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
   // Engine phase: resting after enable drop, or counting a half-period.
   typedef enum logic {
      ENG_REST = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_e;

   // Round-to-nearest bias for a FRAC_W-bit fraction.
   function automatic int half_lsb_pos(input int frac_w);
      return frac_w - 1;
   endfunction
endpackage

// File: rtl/ftg_rounder.sv
module ftg_rounder #(
   parameter int INT_W    = 8,
   parameter int FRAC_W   = 24,
   parameter int CNT_W    = 8,
   parameter int OVERHEAD = 2
) (
   input  logic [INT_W+FRAC_W-1:0]        word_sel,
   input  logic signed [INT_W+FRAC_W-1:0] acc,
   output logic [CNT_W-1:0]               net,
   output logic                           clamp,
   output logic signed [INT_W+FRAC_W-1:0] acc_next
);
   import ftg_pkg::*;

   localparam int WORD_W  = INT_W + FRAC_W;
   localparam int EXT_W   = WORD_W + 2;
   localparam int RAW_W   = EXT_W - FRAC_W;
   localparam int NET_MAX = (1 << CNT_W) - 1;

   logic signed [EXT_W-1:0] w_ext;
   logic signed [EXT_W-1:0] a_ext;
   logic signed [EXT_W-1:0] bias;
   logic signed [EXT_W-1:0] biased;
   logic signed [EXT_W-1:0] acc_sum;
   logic signed [RAW_W-1:0] raw;
   int                      net_wide;

   always_comb begin
      w_ext  = {2'b00, word_sel};
      a_ext  = {{(EXT_W-WORD_W){acc[WORD_W-1]}}, acc};
      bias   = '0;
      bias[half_lsb_pos(FRAC_W)] = 1'b1;
      biased = w_ext - a_ext + bias;
      // arithmetic shift right by FRAC_W: keep the upper bits of the signed sum
      raw    = biased[EXT_W-1:FRAC_W];
      acc_sum = a_ext + {raw, {FRAC_W{1'b0}}} - w_ext;
      acc_next = acc_sum[WORD_W-1:0];

      net_wide = int'(raw) - OVERHEAD;
      clamp    = 1'b0;
      if (net_wide < 1) begin
         net   = CNT_W'(1);
         clamp = 1'b1;
      end else if (net_wide > NET_MAX) begin
         net   = CNT_W'(NET_MAX);
         clamp = 1'b1;
      end else begin
         net   = CNT_W'(net_wide);
      end
   end
endmodule

// File: rtl/ftg_batch.sv
module ftg_batch #(
   parameter int WORD_W = 32,
   parameter int BATCH  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     load,
   input  logic [WORD_W-1:0]        word_in,
   input  logic signed [WORD_W-1:0] acc_next,
   output logic [WORD_W-1:0]        word_sel,
   output logic signed [WORD_W-1:0] acc
);
   localparam int IDX_W = (BATCH > 1) ? $clog2(BATCH) : 1;

   // error accumulator: cleared only by reset or enable drop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (!en) begin
         acc <= '0;
      end else if (load) begin
         acc <= acc_next;
      end
   end

   generate
      if (BATCH == 1) begin : g_follow
         assign word_sel = word_in;
      end else begin : g_hold
         logic [IDX_W-1:0]  idx;
         logic [WORD_W-1:0] held;
         logic              first;

         assign first    = (idx == '0);
         assign word_sel = first ? word_in : held;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx  <= '0;
               held <= '0;
            end else if (!en) begin
               idx  <= '0;
               held <= '0;
            end else if (load) begin
               if (first) begin
                  held <= word_in;
               end
               if (idx == IDX_W'(BATCH - 1)) begin
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ftg_engine.sv
module ftg_engine #(
   parameter int CNT_W    = 8,
   parameter int OVERHEAD = 2,
   parameter bit DEBUG_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] net,
   output logic             load,
   output logic             wave,
   output logic [CNT_W-1:0] half_cnt
);
   import ftg_pkg::*;

   localparam int CD_W = CNT_W + 1;

   eng_state_e       state;
   logic [CD_W-1:0]  cd;

   // a new half-period starts on the first enabled edge and whenever the countdown ends
   assign load = en && ((state == ENG_REST) || (cd == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ENG_REST;
         cd    <= '0;
         wave  <= 1'b0;
      end else if (!en) begin
         state <= ENG_REST;
         cd    <= '0;
         wave  <= 1'b0;
      end else if (load) begin
         state <= ENG_RUN;
         cd    <= CD_W'(net) + CD_W'(OVERHEAD - 1);
         wave  <= ~wave;
      end else begin
         cd    <= cd - 1'b1;
      end
   end

   generate
      if (DEBUG_EN) begin : g_dbg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               half_cnt <= '0;
            end else if (!en) begin
               half_cnt <= '0;
            end else if (load) begin
               half_cnt <= net;
            end
         end
      end else begin : g_nodbg
         assign half_cnt = '0;
      end
   endgenerate
endmodule

// File: rtl/frac_toggle_gen.sv
module frac_toggle_gen #(
   parameter int INT_W    = 8,
   parameter int FRAC_W   = 24,
   parameter int CNT_W    = 8,
   parameter int BATCH    = 32,
   parameter int OVERHEAD = 2,
   parameter bit DEBUG_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [INT_W+FRAC_W-1:0] word,
   output logic                    wave,
   output logic [CNT_W-1:0]        half_cnt,
   output logic                    clamp_flag
);
   localparam int WORD_W = INT_W + FRAC_W;

   generate
      if (OVERHEAD < 1 || OVERHEAD >= (1 << CNT_W)) begin : g_bad_ovh
         $error("OVERHEAD must lie in 1 .. 2**CNT_W-1");
      end
      if (FRAC_W < 2 || INT_W < 1) begin : g_bad_fmt
         $error("word format needs INT_W >= 1 and FRAC_W >= 2");
      end
      if (CNT_W > INT_W + 1) begin : g_bad_cnt
         $error("CNT_W may exceed INT_W by at most one bit");
      end
      if (BATCH < 1) begin : g_bad_batch
         $error("BATCH must be at least 1");
      end
   endgenerate

   logic [WORD_W-1:0]        word_sel;
   logic signed [WORD_W-1:0] acc;
   logic signed [WORD_W-1:0] acc_next;
   logic [CNT_W-1:0]         net;
   logic                     clamp;
   logic                     load;

   ftg_batch #(.WORD_W(WORD_W), .BATCH(BATCH)) u_batch (
      .clk(clk), .rst_n(rst_n), .en(en), .load(load),
      .word_in(word), .acc_next(acc_next),
      .word_sel(word_sel), .acc(acc)
   );

   ftg_rounder #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .OVERHEAD(OVERHEAD)) u_round (
      .word_sel(word_sel), .acc(acc),
      .net(net), .clamp(clamp), .acc_next(acc_next)
   );

   ftg_engine #(.CNT_W(CNT_W), .OVERHEAD(OVERHEAD), .DEBUG_EN(DEBUG_EN)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en), .net(net),
      .load(load), .wave(wave), .half_cnt(half_cnt)
   );

   // sticky clamp record, cleared by reset only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clamp_flag <= 1'b0;
      end else if (load && clamp) begin
         clamp_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/frac_toggle_chk.sv
module frac_toggle_chk #(
   parameter int CNT_W    = 8,
   parameter bit DEBUG_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             wave,
   input logic [CNT_W-1:0] half_cnt,
   input logic             clamp_flag
);
   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !wave);

   assert_start_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |=> wave);

   assert_clamp_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_flag |=> clamp_flag);

   // R9: a toggle made while running is followed by at least one steady cycle
   assert_min_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (wave != $past(wave))) |=> $stable(wave));

   assert_cnt_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (DEBUG_EN && en && $past(en) && (wave != $past(wave))) |-> (half_cnt != '0));
endmodule

bind frac_toggle_gen frac_toggle_chk #(.CNT_W(CNT_W), .DEBUG_EN(DEBUG_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .wave(wave),
   .half_cnt(half_cnt), .clamp_flag(clamp_flag)
);

// File: tb/sim_frac_toggle_gen.sv
`timescale 1ns/1ps
module sim_frac_toggle_gen;
   localparam int  OH    = 2;
   localparam int  BATCH = 32;
   localparam int  LONG_N = 16384;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [31:0] word = '0;
   logic        wave;
   logic [7:0]  half_cnt;
   logic        clamp_flag;

   always #2.5 clk = ~clk;

   frac_toggle_gen #(.OVERHEAD(OH), .BATCH(BATCH)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .word(word),
      .wave(wave), .half_cnt(half_cnt), .clamp_flag(clamp_flag)
   );

   typedef struct {
      int    dur;
      int    net;
      string req;
   } exp_t;

   exp_t    q[$];
   int      checks = 0;
   int      fails = 0;
   longint  cyc = 0;
   int      loads = 0;
   longint  first_cyc = 0;
   longint  last_cyc = 0;
   int      pend_dur = 0;
   string   pend_req = "R2";
   bit      have_prev = 1'b0;
   bit      mon_on = 1'b0;
   logic    last_wave = 1'b0;
   bit      done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // scoreboard feeder: expected half-periods from the requirement formulas
   task automatic push_phase(input longint a, input longint b, input int k,
                             input int n, input string req);
      longint m_acc = 0;
      longint m_held = 0;
      int     m_idx = 0;
      for (int i = 0; i < n; i++) begin
         longint w_in, sum, raw;
         int     net;
         exp_t   e;
         w_in = (i < k) ? a : b;
         if (m_idx == 0) m_held = w_in;
         sum = m_held - m_acc + 64'sd8388608;
         raw = sum >>> 24;
         net = int'(raw) - OH;
         if (net < 1) net = 1;
         if (net > 255) net = 255;
         e.dur = net + OH;
         e.net = net;
         e.req = req;
         q.push_back(e);
         m_acc = m_acc + (raw <<< 24) - m_held;
         m_acc = longint'(int'(m_acc));
         m_idx = (m_idx + 1) % BATCH;
      end
   endtask

   // monitor: every change of wave while enabled is a new half-period
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         if (mon_on && (wave !== last_wave)) begin
            if (have_prev) begin
               chk((cyc - last_cyc) == pend_dur, pend_req, "half-period length",
                   cyc - last_cyc, pend_dur);
            end else begin
               first_cyc = cyc;
            end
            if (q.size() == 0) begin
               chk(1'b0, "R2", "unexpected toggle", loads, -1);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(half_cnt == e.net[7:0], "R7", "half_cnt", half_cnt, e.net);
               pend_dur = e.dur;
               pend_req = e.req;
            end
            have_prev = 1'b1;
            last_cyc  = cyc;
            loads++;
         end
         last_wave = wave;
      end
   end

   task automatic start_phase(input longint a, input longint b, input int k,
                              input int n, input string req);
      push_phase(a, b, k, n, req);
      @(negedge clk);
      have_prev = 1'b0;
      loads     = 0;
      last_wave = 1'b0;
      mon_on    = 1'b1;
      word      = a[31:0];
      en        = 1'b1;
      @(posedge clk);
      #2;
      chk(wave == 1'b1, "R1", "wave after first enabled edge", wave, 1);
      if (k < n) begin
         do @(negedge clk); while (loads < k);
         word = b[31:0];
      end
      do @(negedge clk); while (loads < n);
   endtask

   task automatic stop_phase();
      mon_on = 1'b0;
      en     = 1'b0;
      @(negedge clk);
      chk(wave == 1'b0, "R1", "wave after enable drop", wave, 0);
      q.delete();
   endtask

   initial begin
      longint total, diff;
      longint lw;
      repeat (4) @(posedge clk);
      #1;
      chk(wave == 1'b0, "R1", "wave in reset", wave, 0);
      chk(half_cnt == 8'd0, "R7", "half_cnt in reset", half_cnt, 0);
      chk(clamp_flag == 1'b0, "R6", "clamp_flag in reset", clamp_flag, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(wave == 1'b0, "R1", "wave idle after reset", wave, 0);

      // R2: integer word, five-cycle half-periods
      start_phase(64'h0500_0000, 64'h0500_0000, 40, 40, "R2");
      stop_phase();

      // R4: quarter fraction, error carried across batches
      start_phase(64'h0440_0000, 64'h0440_0000, 70, 70, "R4");
      stop_phase();

      // R3: exact half rounds up on the first half-period
      start_phase(64'h0480_0000, 64'h0480_0000, 12, 12, "R3");
      stop_phase();

      // R5: word change in mid-batch waits for the next batch
      start_phase(64'h0480_0000, 64'h0620_0000, 5, 70, "R5");
      stop_phase();

      // R10: restart after a drop repeats the sequence from a cleared loop
      start_phase(64'h0440_0000, 64'h0440_0000, 10, 10, "R10");
      stop_phase();
      start_phase(64'h0440_0000, 64'h0440_0000, 20, 20, "R10");
      stop_phase();

      chk(clamp_flag == 1'b0, "R6", "clamp_flag before clamp", clamp_flag, 0);
      // R6: 2.2 cycles leaves net below one -> clamped
      start_phase(64'h0233_3333, 64'h0233_3333, 40, 40, "R6");
      stop_phase();
      chk(clamp_flag == 1'b1, "R6", "clamp_flag after clamp", clamp_flag, 1);
      start_phase(64'h0500_0000, 64'h0500_0000, 10, 10, "R6");
      stop_phase();
      chk(clamp_flag == 1'b1, "R6", "clamp_flag stays set", clamp_flag, 1);

      // R8: long-run average
      lw = 64'h0537_A5C3;
      start_phase(lw, lw, LONG_N + 1, LONG_N + 1, "R8");
      total = last_cyc - first_cyc;
      diff  = (total <<< 24) - (longint'(LONG_N) * lw);
      if (diff < 0) diff = -diff;
      chk(diff < 64'sd16777216, "R8", "scaled drift over long run", diff, 0);
      stop_phase();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule